// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

This block sits between a set of interrupt sources and a processor's normal interrupt line. Software binds up to sixteen sources to numbered vector slots. Slot 0 has the highest priority. Each slot has its own handler address, and one further default level catches every other source. The block keeps a current service priority. While a handler runs, the interrupt request only passes sources whose slots rank strictly above the level being served.

A handler starts by reading the vector word. The read returns the handler address of the best pending level and raises the service priority to that level. The old priority is saved in a small per-level record. When the handler is done, it writes any value to the same word. The saved priority then comes back, so handlers can nest.

All state is set through a simple strobed register bus. Read data and the interrupt request both come from registers.

Top module: `vic_top`

## Requirements
- R1: After reset all slot addresses, control bytes and the default address read as zero, the service level is idle (17), and `irq_out` is low.
- R2: Slot k's handler address reads and writes at byte offset 0x100+4k. Its control byte is at 0x200+4k and reads back in bits 7:0 with the upper bits zero. The default address is at byte offset 0x34. Any other offset reads zero.
- R3: In a control byte, bit 5 enables the slot and bits 4:0 name the source it serves. A disabled slot never takes part in masking or acknowledge.
- R4: At the idle level, `irq_out` is high exactly when `en_status` is non-zero.
- R5: While level L is in service, `irq_out` is high only if `en_status` has a bit set for a source bound to an enabled slot with index below L. At level 16 this covers every enabled slot.
- R6: A read strobe on the vector word (offset 0x30) selects the lowest level index below the current one that is pending. Slot k is pending when it is enabled and its source bit in `raw_irq` is set. Level 16 is pending when any `raw_irq` bit is set. The read returns that level's address, where level 16 uses the default address. That level becomes current.
- R7: A vector read that finds no pending level returns the default address and leaves the service level unchanged.
- R8: A write strobe of any value to the vector word restores the level saved when the current level was entered. At idle the write has no effect.
- R9: Without a read or write strobe, an address on the bus changes nothing, even if it is the vector word's address.
- R10: `bus_rdata` and `irq_out` are registered. Read data appears the cycle after the strobe, and `irq_out` follows a change of level, table or `en_status` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_irq | input | 32 | Raw pending sources, used for acknowledge |
| en_status | input | 32 | Enabled normal-interrupt status, used for the request |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that the service level stays in range and never changes without a strobe on the vector word. They also check that an acknowledge can only raise priority, that an end-of-service write at idle leaves the level idle, and that `irq_out` stays low one cycle after `en_status` is all zero. Some behaviour only the bench's scenarios can show. This covers which address an acknowledge returns, correct masking at each nested level, the exact restore order of the nesting record, and register readback. The bench checks these against a reference model it builds from the requirements, using directed nesting cases and randomised programming, source and service sequences.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int BUS_AW       = 12;
  localparam int WORD_AW      = BUS_AW - 2;
  localparam int CTRL_W       = 8;
  localparam int CTRL_EN_BIT  = 5;
  localparam logic [WORD_AW-1:0] W_VECTOR   = 10'd12;
  localparam logic [WORD_AW-1:0] W_DEFAULT  = 10'd13;
  localparam logic [WORD_AW-1:0] W_ADDR_TAB = 10'h040;
  localparam logic [WORD_AW-1:0] W_CTRL_TAB = 10'h080;

  typedef enum logic [2:0] {
    RG_NONE, RG_VECTOR, RG_DEFAULT, RG_ADDR, RG_CTRL
  } reg_kind_e;
endpackage

// File: rtl/vic_regs.sv
module vic_regs import vic_pkg::*; #(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr,
  input  reg_kind_e                           kind,
  input  logic [IDX_W-1:0]                    idx,
  input  logic [DATA_W-1:0]                   wdata,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]    addr_q,
  output logic [NUM_SLOTS-1:0][CTRL_W-1:0]    ctrl_q,
  output logic [DATA_W-1:0]                   def_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ctrl_q <= '0;
      def_q  <= '0;
    end else if (wr) begin
      case (kind)
        RG_ADDR:    addr_q[idx] <= wdata;
        RG_CTRL:    ctrl_q[idx] <= wdata[CTRL_W-1:0];
        RG_DEFAULT: def_q       <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vic_mask_gen.sv
module vic_mask_gen import vic_pkg::*; #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_SRC   = 32,
  localparam int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic [NUM_SLOTS-1:0][CTRL_W-1:0]   ctrl_q,
  input  logic [NUM_SRC-1:0]                 raw_irq,
  output logic [NUM_SLOTS+1:0][NUM_SRC-1:0]  level_mask,
  output logic [NUM_SLOTS:0]                 level_hit
);
  assign level_mask[0] = '0;
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic             en_k;
    logic [SRC_W-1:0] src_k;
    assign en_k  = ctrl_q[k][CTRL_EN_BIT];
    assign src_k = ctrl_q[k][SRC_W-1:0];
    if (k < NUM_SLOTS - 1) begin : g_chain
      assign level_mask[k+1] = level_mask[k] |
        (en_k ? (NUM_SRC'(1) << src_k) : '0);
    end else begin : g_last
      assign level_mask[k+1] = level_mask[k] |
        (en_k ? (NUM_SRC'(1) << src_k) : '0);
    end
    assign level_hit[k] = en_k & raw_irq[src_k];
  end
  assign level_mask[NUM_SLOTS+1] = '1;
  assign level_hit[NUM_SLOTS]    = |raw_irq;
endmodule

// File: rtl/vic_prio_track.sv
module vic_prio_track #(
  parameter int NUM_SLOTS = 16,
  localparam int LEVELS   = NUM_SLOTS + 1,
  localparam int PW       = $clog2(NUM_SLOTS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  input  logic             eoi,
  input  logic [NUM_SLOTS:0] level_hit,
  output logic [PW-1:0]    prio,
  output logic             found,
  output logic [PW-1:0]    target
);
  localparam logic [PW-1:0] IDLE = PW'(LEVELS);
  logic [PW-1:0] saved [LEVELS];

  always_comb begin
    found  = 1'b0;
    target = IDLE;
    for (int k = NUM_SLOTS; k >= 0; k--) begin
      if (PW'(k) < prio && level_hit[k]) begin
        found  = 1'b1;
        target = PW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio <= IDLE;
      for (int k = 0; k < LEVELS; k++) saved[k] <= IDLE;
    end else if (ack && found) begin
      saved[target] <= prio;
      prio          <= target;
    end else if (eoi && prio < IDLE) begin
      prio <= saved[prio];
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top import vic_pkg::*; #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_SRC   = 32,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int PW       = $clog2(NUM_SLOTS + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] raw_irq,
  input  logic [NUM_SRC-1:0] en_status,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out
);
  logic [WORD_AW-1:0] word;
  reg_kind_e          kind;
  logic [IDX_W-1:0]   idx;

  logic [NUM_SLOTS-1:0][DATA_W-1:0]   addr_q;
  logic [NUM_SLOTS-1:0][CTRL_W-1:0]   ctrl_q;
  logic [DATA_W-1:0]                  def_q;
  logic [NUM_SLOTS+1:0][NUM_SRC-1:0]  level_mask;
  logic [NUM_SLOTS:0]                 level_hit;
  logic [PW-1:0]                      prio, target;
  logic                               found;
  logic [DATA_W-1:0]                  rd_next, vec_val;

  assign word = bus_addr[BUS_AW-1:2];
  assign idx  = word[IDX_W-1:0];

  always_comb begin
    kind = RG_NONE;
    if (word == W_VECTOR)                       kind = RG_VECTOR;
    else if (word == W_DEFAULT)                 kind = RG_DEFAULT;
    else if (word >= W_ADDR_TAB &&
             word <  W_ADDR_TAB + WORD_AW'(NUM_SLOTS)) kind = RG_ADDR;
    else if (word >= W_CTRL_TAB &&
             word <  W_CTRL_TAB + WORD_AW'(NUM_SLOTS)) kind = RG_CTRL;
  end

  vic_regs #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .kind(kind), .idx(idx),
    .wdata(bus_wdata), .addr_q(addr_q), .ctrl_q(ctrl_q), .def_q(def_q)
  );

  vic_mask_gen #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC)) u_mask (
    .ctrl_q(ctrl_q), .raw_irq(raw_irq),
    .level_mask(level_mask), .level_hit(level_hit)
  );

  vic_prio_track #(.NUM_SLOTS(NUM_SLOTS)) u_prio (
    .clk(clk), .rst(rst),
    .ack(bus_rd && kind == RG_VECTOR),
    .eoi(bus_wr && kind == RG_VECTOR),
    .level_hit(level_hit), .prio(prio), .found(found), .target(target)
  );

  always_comb begin
    vec_val = def_q;
    if (found && target < PW'(NUM_SLOTS)) vec_val = addr_q[target[IDX_W-1:0]];
  end

  always_comb begin
    case (kind)
      RG_VECTOR:  rd_next = vec_val;
      RG_DEFAULT: rd_next = def_q;
      RG_ADDR:    rd_next = addr_q[idx];
      RG_CTRL:    rd_next = DATA_W'(ctrl_q[idx]);
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_next;
      irq_out <= |(en_status & level_mask[prio]);
    end
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_SRC   = 32,
  localparam int PW       = $clog2(NUM_SLOTS + 2)
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic [11:0]        bus_addr,
  input logic [NUM_SRC-1:0] en_status,
  input logic               irq_out,
  input logic [PW-1:0]      cur_prio
);
  localparam logic [PW-1:0] IDLE = PW'(NUM_SLOTS + 1);
  logic vec_acc;
  assign vec_acc = bus_addr == 12'h030;

  p_range_r1: assert property (@(posedge clk) disable iff (rst)
    cur_prio <= IDLE);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> cur_prio == IDLE && !irq_out);
  p_ack_raises_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && vec_acc) |=> cur_prio <= $past(cur_prio));
  p_idle_eoi_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && vec_acc && cur_prio == IDLE) |=> cur_prio == IDLE);
  p_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && vec_acc) && !(bus_wr && vec_acc) |=> $stable(cur_prio));
  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (en_status == '0) |=> !irq_out);
endmodule

bind vic_top vic_checker #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .en_status(en_status), .irq_out(irq_out),
  .cur_prio(prio)
);

// File: tb/test_vic_top.sv
`timescale 1ns/1ps
module test_vic_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] raw_irq = '0, en_status = '0, bus_wdata = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0, errors = 0;
  logic [31:0] m_addr [16];
  logic [7:0]  m_ctrl [16];
  logic [31:0] m_def;
  int          m_prio;
  int          m_saved [17];

  always #2.5 clk = ~clk;

  vic_top i_vic_top (
    .clk(clk), .rst(rst), .raw_irq(raw_irq), .en_status(en_status),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_mask(int lvl);
    logic [31:0] m = '0;
    if (lvl >= 17) return '1;
    for (int k = 0; k < lvl; k++)
      if (m_ctrl[k][5]) m[m_ctrl[k][4:0]] = 1'b1;
    return m;
  endfunction

  function automatic logic f_irq();
    return |(en_status & f_mask(m_prio));
  endfunction

  function automatic int f_target();
    for (int k = 0; k < m_prio; k++) begin
      if (k < 16 && m_ctrl[k][5] && raw_irq[m_ctrl[k][4:0]]) return k;
      if (k == 16 && raw_irq != 0) return 16;
    end
    return -1;
  endfunction

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a >= 12'h100 && a < 12'h140) m_addr[(a - 12'h100) >> 2] = d;
    else if (a >= 12'h200 && a < 12'h240) m_ctrl[(a - 12'h200) >> 2] = d[7:0];
    else if (a == 12'h034) m_def = d;
    else if (a == 12'h030 && m_prio < 17) m_prio = m_saved[m_prio];
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack(string req);
    logic [31:0] d, exp;
    int t;
    t = f_target();
    if (t < 0) exp = m_def;
    else exp = (t == 16) ? m_def : m_addr[t];
    bus_read(12'h030, d);
    check(req, d, exp);
    if (t >= 0) begin m_saved[t] = m_prio; m_prio = t; end
  endtask

  task automatic check_irq(string req);
    @(negedge clk);
    check(req, {31'd0, irq_out}, {31'd0, f_irq()});
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 16; k++) begin m_addr[k] = 0; m_ctrl[k] = 0; end
    for (int k = 0; k < 17; k++) m_saved[k] = 17;
    m_def = 0; m_prio = 17;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'd0, irq_out}, 32'd0);
    bus_read(12'h100, d); check("R1 addr0", d, 0);
    bus_read(12'h23C, d); check("R1 ctrl15", d, 0);
    bus_read(12'h034, d); check("R1 default", d, 0);

    // R2 register map
    bus_write(12'h104, 32'hA000_0104); bus_read(12'h104, d); check("R2 addr1", d, 32'hA000_0104);
    bus_write(12'h208, 32'hFFFF_FFFF); bus_read(12'h208, d); check("R2 ctrl2 width", d, 32'h0000_00FF);
    bus_write(12'h034, 32'hDEF0_0000); bus_read(12'h034, d); check("R2 default", d, 32'hDEF0_0000);
    bus_read(12'h010, d); check("R2 unmapped", d, 0);

    // R4 idle request
    en_status = 32'h0000_0800; check_irq("R4 idle any");
    check("R10 irq level", {31'd0, irq_out}, 32'd1);
    en_status = 0; check_irq("R4 idle none");

    // Nested scenario: slots 0,1,2 bound to sources 3,7,9; slot 2 ctrl rewritten
    bus_write(12'h100, 32'h1000_0000); bus_write(12'h200, 32'h23);
    bus_write(12'h104, 32'h1100_0000); bus_write(12'h204, 32'h27);
    bus_write(12'h108, 32'h1200_0000); bus_write(12'h208, 32'h29);
    bus_write(12'h10C, 32'h1300_0000); bus_write(12'h20C, 32'h0B); // R3 disabled slot, source 11
    raw_irq = 32'h0000_0800; ack("R3 disabled slot falls to default");
    check("R6 default level", m_prio, 16);
    en_status = 32'h0000_0800; check_irq("R5 level16 blocks unbound");
    en_status = 32'h0000_0200; check_irq("R5 level16 passes slot2 source");
    raw_irq = 32'h0000_0200; ack("R6 slot2 ack");
    check("R6 slot2 level", m_prio, 2);
    en_status = 32'h0000_0200; check_irq("R5 own source masked");
    check("R5 own masked value", {31'd0, irq_out}, 0);
    en_status = 32'h0000_0080; check_irq("R5 higher source passes");
    raw_irq = 32'h0000_0280; ack("R6 nested slot1");
    check("R6 nested level", m_prio, 1);
    raw_irq = 32'h0000_0200; ack("R7 no pending returns default");
    check("R7 level kept", m_prio, 1);
    // R9 address on vector word without strobes
    @(negedge clk); bus_addr = 12'h030; repeat (3) @(negedge clk);
    en_status = 32'h0000_0008; check_irq("R9 no strobe no change");
    bus_write(12'h030, 32'h0); check("R8 pop to 2", m_prio, 2);
    en_status = 32'h0000_0080; check_irq("R8 restored level 2");
    bus_write(12'h030, 32'h5); bus_write(12'h030, 32'h5);
    check("R8 back to idle", m_prio, 17);
    en_status = 32'h0000_0800; check_irq("R8 idle restored");
    bus_write(12'h030, 32'h0); check_irq("R8 idle eoi no effect");

    // Randomised phase
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      int s  = $urandom_range(0, 15);
      case (op)
        0: bus_write(12'(12'h100 + 4*s), $urandom());
        1: bus_write(12'(12'h200 + 4*s), ($urandom_range(0,3) != 0 ? 32'h20 : 32'h0) | $urandom_range(0, 31));
        2, 3: begin raw_irq = $urandom() & $urandom(); en_status = $urandom() & $urandom() & $urandom(); end
        4, 5, 6: ack("R6 random ack");
        7, 8: bus_write(12'h030, $urandom());
        default: bus_write(12'h034, $urandom());
      endcase
      check_irq("R5 random request");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule